// File: doc/BRIEF.md
# Register-Mapped SPI Shift Engine

This block is an SPI master for a host that controls it through a 32-bit register bus. Software writes the divider and the outgoing word, then writes a single shift-control word. That word carries a start bit, a choice among three active-low chip selects, a release flag and a bit count of up to 32. The engine then clocks the bits out on MOSI in SPI mode 0 and collects MISO into a receive word. When the last bit is done it clears the start bit, so software polls that bit to learn that the transfer has finished.

A chunk whose release flag is clear leaves its chip select asserted after it ends. A longer transfer can therefore be built from several 32-bit chunks that are issued back to back. While the enable bit is clear, the pins follow a pin-control register instead of the engine. After reset that register holds every chip select high and SCK and MOSI low.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset, every chip select is high and SCK and MOSI are low. The pin-control register (offset 0x08) reads 0x00070000. The enable register (0x00), the shift-control register (0x14) and the receive register (0x18) read 0.
- R2: While enable bit 0 is clear, the pins follow the pin-control register: csN = bits 18:16, SCK = bit 8 and MOSI = bit 0. A start written to 0x14 is ignored, and bit 31 reads 0.
- R3: With enable set, writing 0x14 with bit 31 set and a count N of 1 to 32 in bits 5:0 starts a shift. Bit 31 reads 1 from the cycle after the write until 2·(div+1)·N cycles after the write, where div is clock-control bits 5:0 (offset 0x04).
- R4: SCK idles low. Each half period lasts div+1 system cycles. The first rising edge comes div+1 cycles after the start, so chip select leads the first edge by one half period.
- R5: The low N bits of the transmit register (0x10) are sent most-significant first, so bit N-1 goes out first. MOSI changes only at falling SCK edges and holds steady while SCK is high.
- R6: MISO is sampled at each rising SCK edge and shifted into the receive register from bit 0. After N bits, the receive register holds the received bits with the last one in bit 0 and zeros above.
- R7: Bits 28+n (n = 0..2) of the shift-control word select csN[n]. If more than one is set, the lowest one wins. That chip select goes low at the start.
- R8: If bit 26 is set, the chip select goes high when the shift completes. If bit 26 is clear, the chip select stays low after completion until a later chunk with bit 26 set completes. The readback of 0x14 shows the selected chip select in bits 30:28, the release flag in bit 26 and the count in bits 5:0.
- R9: A write to 0x14 while a shift is running is ignored, and that includes the cycle in which the shift completes. The running shift and the readback fields do not change.
- R10: A start with a count of 0 is ignored: bit 31 reads 0 and no chip select is asserted.
- R11: The divider is latched at the start. Writing the clock-control register during a shift does not change the timing of that shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Register byte offset |
| busWrite | input | 1 | Write strobe, sampled at the rising clock edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| sck | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| csN | output | 3 | Active-low chip selects |

## Verification
Two events can fall in the same clock edge: the final falling SCK edge that ends a shift, and a new write to the shift-control register. The bench starts a four-bit shift at the fastest rate and counts negedges so that a second start lands exactly on the completion edge. At that edge the engine still reports busy, so the second start must be dropped. This is judged at the ports: bit 31 reads 0, the count field still shows the first chunk, and every chip select is high afterwards. A start one cycle later is accepted normally.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;

  localparam logic [7:0] OFF_ENABLE = 8'h00;
  localparam logic [7:0] OFF_CLOCK  = 8'h04;
  localparam logic [7:0] OFF_PINS   = 8'h08;
  localparam logic [7:0] OFF_TXDATA = 8'h10;
  localparam logic [7:0] OFF_SHIFT  = 8'h14;
  localparam logic [7:0] OFF_RXDATA = 8'h18;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic load;    // start accepted: align tx word, clear rx
    logic sample;  // rising SCK edge: capture MISO
    logic shift;   // falling SCK edge with bits left: next MOSI bit
    logic wrTx;    // bus write to the transmit register
  } strobe_t;

endpackage

// File: rtl/spi_shift_ctrl.sv
module spi_shift_ctrl
  import spi_shift_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int DIV_W     = 6,
  parameter int NUM_CS    = 3,
  parameter int START_BIT = 31,
  parameter int SEL_LSB   = 28,
  parameter int TERM_BIT  = 26,
  parameter int PIN_CS_LSB = 16,
  localparam int CNT_W    = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  output logic              enBit,
  output logic [DIV_W-1:0]  divReg,
  output logic [DATA_W-1:0] pinReg,
  output logic [DATA_W-1:0] shiftRead,
  output logic              busy,
  output logic              sckEng,
  output logic [NUM_CS-1:0] csActive,
  output logic [CNT_W-1:0]  loadCount,
  output strobe_t           strb
);

  localparam logic [DATA_W-1:0] PIN_RESET = DATA_W'({NUM_CS{1'b1}}) << PIN_CS_LSB;
  localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(DATA_W);

  logic wrEnable, wrClock, wrPins, wrShift;
  logic startAcc;
  logic [CNT_W-1:0]  rawCount;
  logic [NUM_CS-1:0] selHot;

  logic [NUM_CS-1:0] ctlSel;
  logic              ctlTerm;
  logic [CNT_W-1:0]  ctlCount;
  logic              termReg;
  logic [DIV_W-1:0]  halfLim;
  logic [DIV_W-1:0]  halfCnt;
  logic [CNT_W-1:0]  bitsLeft;
  logic              halfEnd;

  assign wrEnable = busWrite && (busAddr == ADDR_W'(OFF_ENABLE));
  assign wrClock  = busWrite && (busAddr == ADDR_W'(OFF_CLOCK));
  assign wrPins   = busWrite && (busAddr == ADDR_W'(OFF_PINS));
  assign wrShift  = busWrite && (busAddr == ADDR_W'(OFF_SHIFT));

  assign rawCount  = busWdata[CNT_W-1:0];
  assign loadCount = (rawCount > FULL_CNT) ? FULL_CNT : rawCount;

  // Lowest requested chip select wins.
  always_comb begin
    selHot = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (busWdata[SEL_LSB + i]) selHot = NUM_CS'(1) << i;
    end
  end

  assign startAcc = wrShift && !busy && enBit && busWdata[START_BIT] && (rawCount != '0);
  assign halfEnd  = busy && (halfCnt == halfLim);

  always_comb begin
    strb        = '0;
    strb.load   = startAcc;
    strb.sample = halfEnd && !sckEng;
    strb.shift  = halfEnd && sckEng && (bitsLeft > CNT_W'(1));
    strb.wrTx   = busWrite && (busAddr == ADDR_W'(OFF_TXDATA));
  end

  // Register file.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBit    <= 1'b0;
      divReg   <= '0;
      pinReg   <= PIN_RESET;
      ctlSel   <= '0;
      ctlTerm  <= 1'b0;
      ctlCount <= '0;
    end else begin
      if (wrEnable) enBit  <= busWdata[0];
      if (wrClock)  divReg <= busWdata[DIV_W-1:0];
      if (wrPins)   pinReg <= busWdata;
      if (wrShift && !busy) begin
        ctlSel   <= selHot;
        ctlTerm  <= busWdata[TERM_BIT];
        ctlCount <= rawCount;
      end
    end
  end

  // Shift timing and chip-select hold.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      sckEng   <= 1'b0;
      halfCnt  <= '0;
      halfLim  <= '0;
      bitsLeft <= '0;
      csActive <= '0;
      termReg  <= 1'b0;
    end else if (startAcc) begin
      busy     <= 1'b1;
      sckEng   <= 1'b0;
      halfCnt  <= '0;
      halfLim  <= divReg;
      bitsLeft <= loadCount;
      csActive <= selHot;
      termReg  <= busWdata[TERM_BIT];
    end else if (busy) begin
      if (halfEnd) begin
        halfCnt <= '0;
        if (!sckEng) begin
          sckEng <= 1'b1;
        end else begin
          sckEng <= 1'b0;
          if (bitsLeft == CNT_W'(1)) begin
            busy <= 1'b0;
            if (termReg) csActive <= '0;
          end else begin
            bitsLeft <= bitsLeft - CNT_W'(1);
          end
        end
      end else begin
        halfCnt <= halfCnt + DIV_W'(1);
      end
    end
  end

  always_comb begin
    shiftRead = '0;
    shiftRead[START_BIT] = busy;
    shiftRead[SEL_LSB +: NUM_CS] = ctlSel;
    shiftRead[TERM_BIT] = ctlTerm;
    shiftRead[CNT_W-1:0] = ctlCount;
  end

  assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrShift) |=> ($stable(ctlCount) && $stable(ctlSel) && $stable(ctlTerm)));

  assert_cs_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(csActive));

  assert_cs_during_shift_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (csActive != '0));

  assert_sck_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sckEng);

  assert_half_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (halfCnt <= halfLim));

  assert_zero_count_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && wrShift && rawCount == '0) |=> !busy);

  assert_div_latched_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !startAcc) |=> (busy -> $stable(halfLim)));

endmodule

// File: rtl/spi_shift_data.sv
module spi_shift_data
  import spi_shift_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [CNT_W-1:0]  loadCount,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              miso,
  output logic [DATA_W-1:0] txData,
  output logic [DATA_W-1:0] rxData,
  output logic              mosiEng
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);

  logic [DATA_W-1:0] txShift;

  assign mosiEng = txShift[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txData  <= '0;
      txShift <= '0;
      rxData  <= '0;
    end else begin
      if (strb.wrTx) txData <= busWdata;
      if (strb.load) begin
        txShift <= txData << (FULL_CNT - loadCount);
        rxData  <= '0;
      end else begin
        if (strb.shift)  txShift <= txShift << 1;
        if (strb.sample) rxData  <= {rxData[DATA_W-2:0], miso};
      end
    end
  end

  assert_mosi_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.shift) |=> $stable(mosiEng));

  assert_rx_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (rxData == '0));

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_shift_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int DIV_W      = 6,
  parameter int NUM_CS     = 3,
  parameter int PIN_CS_LSB = 16,
  parameter int PIN_SCK    = 8,
  parameter int PIN_MOSI   = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] csN
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  logic              enBit, busy, sckEng, mosiEng;
  logic [DIV_W-1:0]  divReg;
  logic [DATA_W-1:0] pinReg, shiftRead, txData, rxData;
  logic [NUM_CS-1:0] csActive;
  logic [CNT_W-1:0]  loadCount;
  strobe_t           strb;

  spi_shift_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W), .NUM_CS(NUM_CS),
    .PIN_CS_LSB(PIN_CS_LSB)
  ) ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .enBit(enBit), .divReg(divReg), .pinReg(pinReg),
    .shiftRead(shiftRead), .busy(busy), .sckEng(sckEng), .csActive(csActive),
    .loadCount(loadCount), .strb(strb)
  );

  spi_shift_data #(.DATA_W(DATA_W)) dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .loadCount(loadCount),
    .busWdata(busWdata), .miso(miso), .txData(txData), .rxData(rxData),
    .mosiEng(mosiEng)
  );

  always_comb begin
    if (enBit) begin
      sck  = sckEng;
      mosi = busy & mosiEng;
      csN  = ~csActive;
    end else begin
      sck  = pinReg[PIN_SCK];
      mosi = pinReg[PIN_MOSI];
      csN  = pinReg[PIN_CS_LSB +: NUM_CS];
    end
  end

  always_comb begin
    case (busAddr)
      ADDR_W'(OFF_ENABLE): busRdata = DATA_W'(enBit);
      ADDR_W'(OFF_CLOCK):  busRdata = DATA_W'(divReg);
      ADDR_W'(OFF_PINS):   busRdata = pinReg;
      ADDR_W'(OFF_TXDATA): busRdata = txData;
      ADDR_W'(OFF_SHIFT):  busRdata = shiftRead;
      ADDR_W'(OFF_RXDATA): busRdata = rxData;
      default:             busRdata = '0;
    endcase
  end

endmodule

// File: tb/spi_shift_engine_test.sv
module spi_shift_engine_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrite = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        sck, mosi;
  logic        miso = 1'b0;
  logic [2:0]  csN;

  always #4 clk = ~clk;

  spi_shift_engine uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .sck(sck), .mosi(mosi),
    .miso(miso), .csN(csN)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int tests = 0;
  int fails = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  function automatic logic [31:0] ctlWord(input int sel, input bit term, input int n);
    return 32'h8000_0000 | (32'h1 << (28 + sel)) | (32'(term) << 26) | 32'(n);
  endfunction

  typedef struct {
    logic [31:0] bits;
    int          n;
    int          h;
    logic [31:0] rx;
    logic [2:0]  csAfter;
  } item_t;
  item_t expQ[$];

  // Measurements handed from driver and monitor to the scoreboard.
  logic [31:0] gotBits, misoWord, rxRead;
  int  gotN, firstRiseCyc, startCyc, doneCyc, misoIdx, highLen;
  bit  capturing = 0, halfErr, mosiErr, ready = 0;
  logic [2:0] csMeas;
  logic prevSck = 1'b0, prevMosi = 1'b0;

  // Pin monitor and MISO slave model.
  initial forever begin
    @(negedge clk);
    if (capturing) begin
      if (sck && !prevSck) begin
        gotBits = {gotBits[30:0], mosi};
        gotN++;
        if (gotN == 1) firstRiseCyc = cyc;
        highLen = 1;
        misoIdx--;
        miso = (misoIdx >= 0) ? misoWord[misoIdx] : 1'b0;
      end else if (sck) begin
        highLen++;
      end
      if (!sck && prevSck && expQ.size() > 0 && highLen != expQ[0].h) halfErr = 1;
      if (sck && prevSck && mosi != prevMosi) mosiErr = 1;
    end
    prevSck = sck;
    prevMosi = mosi;
  end

  // Scoreboard.
  initial forever begin
    item_t it;
    wait (ready);
    it = expQ.pop_front();
    check(gotN == it.n, "R3", "sck rising edges", gotN, it.n);
    check(firstRiseCyc - startCyc == it.h + 1, "R4", "lead to first edge",
          firstRiseCyc - startCyc, it.h + 1);
    check(!halfErr, "R4", "high half period", halfErr, 0);
    check(doneCyc - startCyc == 2 * it.h * it.n + 1, "R3", "busy duration",
          doneCyc - startCyc, 2 * it.h * it.n + 1);
    check(gotBits == it.bits, "R5", "mosi bits msb first", gotBits, it.bits);
    check(!mosiErr, "R5", "mosi steady while sck high", mosiErr, 0);
    check(rxRead == it.rx, "R6", "receive word", rxRead, it.rx);
    check(csMeas == it.csAfter, "R8", "chip select after chunk", csMeas, it.csAfter);
    ready = 0;
  end

  task automatic runChunk(input int dv, input int sel, input bit term, input int n,
                          input logic [31:0] tx, input logic [31:0] mw, input bit disturb);
    item_t it;
    logic [31:0] d;
    logic [31:0] mask;
    mask = (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
    busWr(8'h04, 32'(dv));
    busWr(8'h10, tx);
    misoWord = mw; misoIdx = n - 1; miso = mw[n-1];
    it.bits = tx & mask; it.n = n; it.h = dv + 1; it.rx = mw & mask;
    it.csAfter = term ? 3'b111 : ~(3'b001 << sel);
    expQ.push_back(it);
    gotBits = '0; gotN = 0; halfErr = 0; mosiErr = 0; capturing = 1;
    @(negedge clk);
    startCyc = cyc;
    busAddr = 8'h14; busWdata = ctlWord(sel, term, n); busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
    // R7: selected chip select low right after the start
    check(csN == ~(3'b001 << sel), "R7", "chip select at start", csN, ~(3'b001 << sel));
    if (disturb) begin
      busWr(8'h14, ctlWord(0, 1'b0, 3)); // R9: ignored while busy
      busWr(8'h04, 32'd5);               // R11: divider change mid-shift
    end
    do busRd(8'h14, d); while (d[31] && (cyc - startCyc) < 5000);
    doneCyc = cyc;
    capturing = 0;
    busRd(8'h18, rxRead);
    csMeas = csN;
    busRd(8'h14, d);
    check(d == (ctlWord(sel, term, n) & 32'h7FFF_FFFF), "R8", "shift readback fields",
          d, ctlWord(sel, term, n) & 32'h7FFF_FFFF);
    ready = 1;
    wait (!ready);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    @(negedge clk);
    check(csN == 3'b111, "R1", "csN after reset", csN, 3'b111);
    check(sck == 1'b0 && mosi == 1'b0, "R1", "sck/mosi after reset", {sck, mosi}, 0);
    busRd(8'h08, d); check(d == 32'h0007_0000, "R1", "pin control", d, 32'h0007_0000);
    busRd(8'h00, d); check(d == 0, "R1", "enable", d, 0);
    busRd(8'h14, d); check(d == 0, "R1", "shift control", d, 0);
    busRd(8'h18, d); check(d == 0, "R1", "receive", d, 0);

    // R2 pins from pin control while disabled; start ignored
    busWr(8'h08, 32'h0005_0101);
    @(negedge clk);
    check(csN == 3'b101 && sck && mosi, "R2", "pins follow register",
          {csN, sck, mosi}, {3'b101, 2'b11});
    busWr(8'h14, ctlWord(1, 1'b1, 8));
    busRd(8'h14, d); check(d[31] == 1'b0, "R2", "start while disabled", d[31], 0);
    check(csN == 3'b101, "R2", "csN unchanged by ignored start", csN, 3'b101);
    busWr(8'h08, 32'h0007_0000);
    busWr(8'h00, 32'h1);

    // Main chunks
    runChunk(0, 0, 1'b1, 8,  32'h0000_00A5, 32'h0000_003C, 1'b0);
    runChunk(2, 1, 1'b0, 32, 32'hDEAD_BEEF, 32'h1234_5678, 1'b0);
    // R8: chip select held between chained chunks
    @(negedge clk);
    check(csN == 3'b101, "R8", "chip select held between chunks", csN, 3'b101);
    runChunk(1, 1, 1'b1, 5,  32'h0000_0013, 32'h0000_0015, 1'b0);
    // R9 and R11: writes during the shift change nothing
    runChunk(3, 2, 1'b1, 12, 32'h0FFF_0A5C, 32'h0000_00F3, 1'b1);
    // R7: lowest of several requested selects wins
    busWr(8'h04, 32'd0);
    @(negedge clk);
    busAddr = 8'h14; busWdata = 32'h8000_0000 | 32'h6000_0000 | 32'h0400_0000 | 32'd2;
    busWrite = 1'b1;
    @(negedge clk); busWrite = 1'b0;
    check(csN == 3'b101, "R7", "lowest selected wins", csN, 3'b101);
    repeat (6) @(negedge clk);

    // Completion-edge collision (R9): 4 bits at div 0 -> done 8 edges after start
    busWr(8'h04, 32'd0);
    busWr(8'h10, 32'h0000_0009);
    @(negedge clk);
    busAddr = 8'h14; busWdata = ctlWord(0, 1'b1, 4); busWrite = 1'b1;
    @(negedge clk); busWrite = 1'b0;
    repeat (6) @(negedge clk);
    busWr(8'h14, ctlWord(1, 1'b1, 7));
    busRd(8'h14, d);
    check(d[31] == 1'b0, "R9", "start on completion edge dropped", d[31], 0);
    check(d[5:0] == 6'd4, "R9", "count kept on completion edge", d[5:0], 4);
    check(csN == 3'b111, "R9", "no chip select after dropped start", csN, 3'b111);
    busWr(8'h14, ctlWord(1, 1'b1, 2));
    busRd(8'h14, d);
    check(d[31] == 1'b1, "R3", "start after completion accepted", d[31], 1);
    repeat (8) @(negedge clk);

    // R10 zero count ignored
    busWr(8'h14, ctlWord(2, 1'b1, 0));
    busRd(8'h14, d);
    check(d[31] == 1'b0, "R10", "zero count start", d[31], 0);
    check(csN == 3'b111, "R10", "no chip select for zero count", csN, 3'b111);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule